// File: doc/BRIEF.md
# Palette Colour Lookup with Streamed Host Access

This block is the host side and the colour table of a 256-entry palette converter. The host reaches it through one narrow register bus with four ports: a pixel mask, a read-side index, a write-side index and a single data port. To load colours, the host sets the write-side index and then streams bytes into the data port. A hidden component counter routes the bytes to red, then green, then blue. After blue the entry is committed and the index moves on by itself. Reading works the same way through a separate read-side index, so a whole table is moved as one unbroken byte stream.

On the display side, each incoming pixel index is ANDed with the mask register. The result selects a table entry, and its three 6-bit components appear on the outputs one clock later. Conversion to analog levels happens outside this block.

Port select encoding on `bus_sel`: 0 is the mask port, 1 is the read-side index (write) or state register (read), 2 is the write-side index (read and write), 3 is the data port. A read or write lasts one cycle, and `bus_rd` and `bus_wr` are never asserted together.

Top module: `palette_dac_host`

## Requirements
- R1: After reset the write-side index and the read-side index are both 0, the mask is 0xFF, the state register reads 0x00, and the three pixel outputs are 0.
- R2: Writing port 2 sets the write-side index. Three data-port writes then fill that entry as red, green, blue. Reading port 2 returns the current write-side index, which is one higher after each completed triple.
- R3: After the blue byte of entry 255 the write-side index wraps to 0. Loading from index 0, 768 consecutive data bytes fill every entry exactly once.
- R4: Writing port 1 sets the read-side index. Data-port reads then return red, green and blue of that entry in turn and move to the next entry, wrapping from 255 to 0.
- R5: Writing either index port returns that side's component counter to red. On the write side, a triple left incomplete leaves its entry unchanged.
- R6: Only bits [5:0] of a data byte are stored. A component read returns those six bits with bits [7:6] zero.
- R7: Port 0 holds the pixel mask. Writing it sets the value and reading it returns the value.
- R8: Reading port 1 returns 0x03 after the last index load was to port 1, and 0x00 after the last index load was to port 2.
- R9: The pixel outputs show the entry at (pix_idx AND mask) one clock after pix_idx is presented.
- R10: `rd_data` takes its new value on the clock edge that ends a read cycle and keeps it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe, one cycle per byte |
| bus_sel | input | 2 | Port select (0 mask, 1 read index/state, 2 write index, 3 data) |
| bus_wdata | input | 8 | Host write byte |
| rd_data | output | 8 | Registered host read byte |
| pix_idx | input | 8 | Pixel colour index |
| pix_red | output | 6 | Red component of the looked-up entry |
| pix_green | output | 6 | Green component of the looked-up entry |
| pix_blue | output | 6 | Blue component of the looked-up entry |

## Verification
The assertions check, on every cycle, the local sequencing rules:
- an index load lands the new index and resets the component counter;
- a completed triple advances the index by one, with wrap;
- the counter never leaves its three legal values;
- an index load sets the state flag;
- a mask write lands its value;
- `rd_data` holds while no read is under way.

Only the bench scenarios can show end-to-end table content. That covers a full 768-byte stream round-trip, truncation to six bits, abandoned triples leaving an entry untouched, wrap at 255 on both sides, and the masked pixel lookup against a model table under random masks and pixel indices.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

  // Host port select codes (field decoded by the bus)
  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  // Colour component currently addressed by a streaming side
  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;

  // Direction of the most recent index load
  typedef enum logic {
    MODE_WRITE = 1'b0,
    MODE_READ  = 1'b1
  } mode_e;

  localparam logic [7:0] STATE_CODE_WRITE = 8'h00;
  localparam logic [7:0] STATE_CODE_READ  = 8'h03;

  // Component after c; blue goes back to red
  function automatic comp_e comp_after(comp_e c);
    case (c)
      COMP_R:  return COMP_G;
      COMP_G:  return COMP_B;
      default: return COMP_R;
    endcase
  endfunction

  function automatic logic [7:0] state_code(mode_e m);
    return (m == MODE_READ) ? STATE_CODE_READ : STATE_CODE_WRITE;
  endfunction

endpackage

// File: rtl/pdac_seq.sv
// Streaming index plus hidden component counter; one per host side.
module pdac_seq
  import pdac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output comp_e            comp,
  output logic             entry_done
);

  function automatic logic [IDX_W-1:0] idx_next(logic [IDX_W-1:0] i);
    return i + 1'b1;  // natural wrap at the top of the table
  endfunction

  // Event: last component of an entry is consumed by this step
  assign entry_done = step && !load && (comp == COMP_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      comp <= COMP_R;
    end else if (load) begin
      idx  <= load_val;
      comp <= COMP_R;
    end else if (step) begin
      comp <= comp_after(comp);
      if (entry_done) idx <= idx_next(idx);
    end
  end

  // R5 / R2: an index load lands the value and restarts at red
  p_load_resets_comp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == $past(load_val)) && (comp == COMP_R));

  // R3 / R4: a finished triple moves to the next entry, wrapping
  p_wrap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && comp == COMP_B) |=>
      (idx == IDX_W'($past(idx) + 1'b1)) && (comp == COMP_R));

  // R5: counter stays within its three legal positions
  p_comp_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    comp != comp_e'(2'd3));

  // R2: a middle step leaves the index alone
  p_mid_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && comp != COMP_B) |=> $stable(idx));

endmodule

// File: rtl/pdac_table.sv
// Colour storage: one write port, two asynchronous read ports.
module pdac_table #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IDX_W-1:0]    waddr,
  input  logic [3*COMP_W-1:0] wentry,
  input  logic [IDX_W-1:0]    raddr_host,
  output logic [3*COMP_W-1:0] rentry_host,
  input  logic [IDX_W-1:0]    raddr_pix,
  output logic [3*COMP_W-1:0] rentry_pix
);

  localparam int DEPTH = 1 << IDX_W;

  logic [3*COMP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  assign rentry_host = mem[raddr_host];
  assign rentry_pix  = mem[raddr_pix];

endmodule

// File: rtl/pdac_pixel.sv
// Masked pixel lookup with one register stage on the colour outputs.
module pdac_pixel #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    pix_idx,
  input  logic [IDX_W-1:0]    mask,
  output logic [IDX_W-1:0]    look_addr,
  input  logic [3*COMP_W-1:0] look_entry,
  output logic [COMP_W-1:0]   red,
  output logic [COMP_W-1:0]   green,
  output logic [COMP_W-1:0]   blue
);

  function automatic logic [IDX_W-1:0] masked(logic [IDX_W-1:0] p,
                                              logic [IDX_W-1:0] m);
    return p & m;
  endfunction

  assign look_addr = masked(pix_idx, mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red   <= '0;
      green <= '0;
      blue  <= '0;
    end else begin
      red   <= look_entry[3*COMP_W-1:2*COMP_W];
      green <= look_entry[2*COMP_W-1:COMP_W];
      blue  <= look_entry[COMP_W-1:0];
    end
  end

  // R9: address bits cleared in the mask never reach the table
  p_mask_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> (look_addr == '0));

endmodule

// File: rtl/palette_dac_host.sv
module palette_dac_host
  import pdac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_sel,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] rd_data,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [COMP_W-1:0] pix_red,
  output logic [COMP_W-1:0] pix_green,
  output logic [COMP_W-1:0] pix_blue
);

  localparam int ENTRY_W = 3 * COMP_W;

  // Keep low component bits of a host byte
  function automatic logic [COMP_W-1:0] clip(logic [BUS_W-1:0] b);
    return b[COMP_W-1:0];
  endfunction

  // Pick one component out of a packed {r,g,b} entry
  function automatic logic [COMP_W-1:0] pick(logic [ENTRY_W-1:0] e, comp_e c);
    case (c)
      COMP_R:  return e[ENTRY_W-1:2*COMP_W];
      COMP_G:  return e[2*COMP_W-1:COMP_W];
      default: return e[COMP_W-1:0];
    endcase
  endfunction

  port_e sel;
  assign sel = port_e'(bus_sel);

  // Named bus events
  logic wr_mask, wr_ridx, wr_widx, wr_data, rd_data_port;
  assign wr_mask      = bus_wr && (sel == PORT_MASK);
  assign wr_ridx      = bus_wr && (sel == PORT_RIDX);
  assign wr_widx      = bus_wr && (sel == PORT_WIDX);
  assign wr_data      = bus_wr && (sel == PORT_DATA);
  assign rd_data_port = bus_rd && (sel == PORT_DATA);

  logic [IDX_W-1:0] mask_q;
  mode_e            mode_q;
  logic [COMP_W-1:0] hold_r, hold_g;

  logic [IDX_W-1:0] widx, ridx;
  comp_e            wcomp, rcomp;
  logic             wr_commit, rd_entry_done;

  pdac_seq #(.IDX_W(IDX_W)) u_wseq (
    .clk(clk), .rst_n(rst_n),
    .load(wr_widx), .load_val(bus_wdata[IDX_W-1:0]),
    .step(wr_data),
    .idx(widx), .comp(wcomp), .entry_done(wr_commit)
  );

  pdac_seq #(.IDX_W(IDX_W)) u_rseq (
    .clk(clk), .rst_n(rst_n),
    .load(wr_ridx), .load_val(bus_wdata[IDX_W-1:0]),
    .step(rd_data_port),
    .idx(ridx), .comp(rcomp), .entry_done(rd_entry_done)
  );

  logic [ENTRY_W-1:0] host_entry, pix_entry, new_entry;
  logic [IDX_W-1:0]   pix_addr;

  assign new_entry = {hold_r, hold_g, clip(bus_wdata)};

  pdac_table #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_table (
    .clk(clk),
    .we(wr_commit), .waddr(widx), .wentry(new_entry),
    .raddr_host(ridx), .rentry_host(host_entry),
    .raddr_pix(pix_addr), .rentry_pix(pix_entry)
  );

  pdac_pixel #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_pixel (
    .clk(clk), .rst_n(rst_n),
    .pix_idx(pix_idx), .mask(mask_q),
    .look_addr(pix_addr), .look_entry(pix_entry),
    .red(pix_red), .green(pix_green), .blue(pix_blue)
  );

  // Control registers and staging of partial triples
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      mode_q <= MODE_WRITE;
      hold_r <= '0;
      hold_g <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata[IDX_W-1:0];
      if (wr_ridx) mode_q <= MODE_READ;
      else if (wr_widx) mode_q <= MODE_WRITE;
      if (wr_data && wcomp == COMP_R) hold_r <= clip(bus_wdata);
      if (wr_data && wcomp == COMP_G) hold_g <= clip(bus_wdata);
    end
  end

  // Registered host read mux
  logic [BUS_W-1:0] rd_next;
  always_comb begin
    case (sel)
      PORT_MASK: rd_next = BUS_W'(mask_q);
      PORT_RIDX: rd_next = BUS_W'(state_code(mode_q));
      PORT_WIDX: rd_next = BUS_W'(widx);
      default:   rd_next = BUS_W'(pick(host_entry, rcomp));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (bus_rd) rd_data <= rd_next;
  end

  // R8: loading the read-side index flips the state flag to read
  p_state_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ridx && !wr_widx) |=> (mode_q == MODE_READ));

  // R7: a mask write lands its value
  p_mask_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(bus_wdata[IDX_W-1:0])));

  // R10: read data holds while no read is under way
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rd_data));

  // R2: reading the data port never commits an entry
  p_no_commit_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> !wr_commit);

endmodule

// File: tb/tb_palette_dac_host.sv
module tb_palette_dac_host;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] rd_data;
  logic [7:0] pix_idx = 8'd0;
  logic [5:0] pix_red, pix_green, pix_blue;

  always #5 clk = ~clk;

  palette_dac_host dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .pix_idx(pix_idx), .pix_red(pix_red), .pix_green(pix_green),
    .pix_blue(pix_blue)
  );

  localparam logic [1:0] S_MASK = 2'd0, S_RIDX = 2'd1, S_WIDX = 2'd2, S_DATA = 2'd3;

  int total = 0, bad = 0;
  logic [5:0] mr [256], mg [256], mb [256];
  logic [7:0] mmask;

  function automatic logic [5:0] six(logic [7:0] b);
    return b & 8'h3F;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] s, input logic [7:0] d);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] s, output logic [7:0] v);
    bus_sel = s; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = rd_data;
  endtask

  task automatic put_entry(input int i, input logic [7:0] r, g, b);
    bwr(S_DATA, r); bwr(S_DATA, g); bwr(S_DATA, b);
    mr[i] = six(r); mg[i] = six(g); mb[i] = six(b);
  endtask

  task automatic get_entry(input string req, input int i);
    logic [7:0] v;
    brd(S_DATA, v); check(req, v, {2'b00, mr[i]});
    brd(S_DATA, v); check(req, v, {2'b00, mg[i]});
    brd(S_DATA, v); check(req, v, {2'b00, mb[i]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: pixel outputs cleared during reset
    check("R1 pix_red", pix_red, 0);
    check("R1 pix_green", pix_green, 0);
    check("R1 pix_blue", pix_blue, 0);
    rst_n = 1'b1;
    @(negedge clk);

    brd(S_MASK, v); check("R1 R7 mask reset", v, 8'hFF);
    brd(S_RIDX, v); check("R1 R8 state reset", v, 8'h00);
    brd(S_WIDX, v); check("R1 write index reset", v, 0);

    // R3 R6: full 768-byte stream from index 0 (reset index, no load)
    for (int i = 0; i < 256; i++)
      put_entry(i, 8'($urandom), 8'($urandom), 8'($urandom));
    brd(S_WIDX, v); check("R3 write index wrapped", v, 0);

    // R1 R4 R6: read all from reset read index 0
    for (int i = 0; i < 256; i++) get_entry("R4 R6 full readback", i);
    brd(S_RIDX, v); check("R8 state still write", v, 8'h00);

    // R2: load write index mid-table, readback after each triple
    bwr(S_WIDX, 8'd100);
    brd(S_WIDX, v); check("R2 write index load", v, 100);
    put_entry(100, 8'hFF, 8'h00, 8'hC5);
    brd(S_WIDX, v); check("R2 write index step", v, 101);
    put_entry(101, 8'h3F, 8'h40, 8'h01);
    brd(S_WIDX, v); check("R2 write index step2", v, 102);

    // R8: state follows last index load
    bwr(S_RIDX, 8'd100);
    brd(S_RIDX, v); check("R8 state read", v, 8'h03);
    get_entry("R2 R6 entry 100", 100);
    get_entry("R2 R4 entry 101", 101);
    bwr(S_WIDX, 8'd7);
    brd(S_RIDX, v); check("R8 state write", v, 8'h00);

    // R3 R4: wrap at 255 on both sides
    bwr(S_WIDX, 8'd254);
    put_entry(254, 8'h11, 8'h22, 8'h33);
    put_entry(255, 8'h21, 8'h32, 8'h03);
    put_entry(0, 8'h05, 8'h06, 8'h07);
    brd(S_WIDX, v); check("R3 wrap to 1", v, 1);
    bwr(S_RIDX, 8'd255);
    get_entry("R4 entry 255", 255);
    get_entry("R4 wrap entry 0", 0);

    // R5: abandoned triple on write side leaves entry untouched
    bwr(S_WIDX, 8'd10);
    bwr(S_DATA, 8'h2A); bwr(S_DATA, 8'h15);
    bwr(S_WIDX, 8'd20);
    brd(S_WIDX, v); check("R5 index after abort", v, 20);
    bwr(S_RIDX, 8'd10);
    get_entry("R5 entry 10 unchanged", 10);
    bwr(S_WIDX, 8'd10);
    bwr(S_DATA, 8'h01);
    bwr(S_WIDX, 8'd10);
    put_entry(10, 8'h0A, 8'h0B, 8'h0C);
    // R5: read side counter restarts on reload
    bwr(S_RIDX, 8'd10);
    brd(S_DATA, v); check("R5 read first comp", v, {2'b00, mr[10]});
    bwr(S_RIDX, 8'd10);
    get_entry("R5 read restart", 10);

    // R10: rd_data holds across writes and idle cycles
    brd(S_MASK, v);
    bwr(S_MASK, 8'h5A);
    @(negedge clk);
    check("R10 rd_data held", rd_data, 8'hFF);
    brd(S_MASK, v); check("R7 mask readback", v, 8'h5A);

    // R9: masked pixel lookup, one cycle latency
    for (int k = 0; k < 4; k++) begin
      mmask = (k == 0) ? 8'hFF : (k == 1) ? 8'h0F : (k == 2) ? 8'h00 : 8'($urandom);
      bwr(S_MASK, mmask);
      for (int n = 0; n < 60; n++) begin
        logic [7:0] p, e;
        p = 8'($urandom);
        pix_idx = p;
        @(negedge clk);
        e = p & mmask;
        check("R9 red", pix_red, mr[e]);
        check("R9 green", pix_green, mg[e]);
        check("R9 blue", pix_blue, mb[e]);
      end
    end
    brd(S_MASK, v); check("R7 mask last", v, mmask);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule